// File: doc/BRIEF.md
# Truncating Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a small fixed-point signal processor. It takes two 16-bit two's-complement operands and forms their 32-bit product. It keeps only the upper 24 bits of that product and combines the result with a 24-bit accumulator in a 24-bit adder/subtractor. The accumulator has no headroom above 24 bits, so every signed overflow is caught at that width. The overflow is then either wrapped or clamped, depending on a mode input.

Each operation is presented with a valid strobe and its two operands. The operation is evaluated combinationally in that cycle. The new accumulator value and its status flags are registered on the next rising clock edge. The flags are zero, negative and a sticky overflow flag. Instruction decode, register files, memory addressing and rounding other than truncation belong to the surrounding processor.

Top module: `mac_trunc_dp`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the accumulator is 0, `zero_o` is 1, `neg_o` is 0 and `ovf_o` is 0.
- R2: Operation code 0 (multiply-load) sets the accumulator to bits [31:8] of the signed product `opa_i*opb_i`, which is floor(product/256). This operation never sets overflow.
- R3: Operation code 1 (multiply-accumulate) adds the truncated product of R2 to the accumulator. When `sat_i` is 0, a result outside the 24-bit signed range wraps modulo 2^24.
- R4: Operation code 2 (multiply-subtract) subtracts the truncated product of R2 from the accumulator, with the same overflow handling as R3.
- R5: Operation codes 3 (add) and 4 (subtract) add `opa_i` sign-extended to 24 bits to the accumulator, or subtract it. `opb_i` has no effect on these operations.
- R6: Operation code 5 (pass) loads the accumulator with `opa_i` sign-extended to 24 bits.
- R7: Operation code 6 (clear) sets the accumulator to 0 and clears `ovf_o`.
- R8: `ovf_o` is set when an add or subtract in codes 1 to 4 leaves the signed 24-bit range. It then stays set until a clear operation or a reset.
- R9: When `sat_i` is 1, an overflowing result is clamped to 0x7FFFFF if it is positive and to 0x800000 if it is negative.
- R10: `zero_o` is 1 exactly when the accumulator is 0, and `neg_o` equals accumulator bit 23, after every update.
- R11: A cycle with `valid_i` low, or one that carries the reserved code 7, changes neither the accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0..6, 7 reserved) |
| opa_i | input | 16 | Signed operand A |
| opb_i | input | 16 | Signed operand B |
| sat_i | input | 1 | 1 = saturate on overflow, 0 = wrap |
| acc_o | output | 24 | Accumulator |
| zero_o | output | 1 | Accumulator equals zero |
| neg_o | output | 1 | Accumulator is negative |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that the zero and negative flags agree with the accumulator. They also check that an idle or reserved cycle leaves all state unchanged and that the overflow flag stays set until it is cleared. In addition, they check that a clear empties the accumulator and that a saturated result is always one of the two clamp values. The arithmetic itself can only be shown by the bench's sweeps against an independent integer model. That includes the floor behaviour of the product truncation, wrap versus clamp at both ends of the range, and the independence of add and subtract from operand B.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned OPND_W = 16;
    localparam int unsigned ACCU_W = 24;

    typedef enum logic [2:0] {
        OP_MLOAD = 3'd0,
        OP_MAC   = 3'd1,
        OP_MSUB  = 3'd2,
        OP_ADD   = 3'd3,
        OP_SUB   = 3'd4,
        OP_PASS  = 3'd5,
        OP_CLR   = 3'd6,
        OP_RSVD  = 3'd7
    } op_e;

    typedef struct packed {
        logic use_prod;   // operand is the truncated product
        logic accumulate; // combine with current accumulator
        logic subtract;   // subtract instead of add
        logic load_zero;  // force accumulator to zero
        logic clr_ovf;    // clear sticky overflow
        logic wr;         // operation updates state
    } ctl_t;

    function automatic ctl_t decode_op(input op_e op);
        ctl_t c;
        c = '0;
        unique case (op)
            OP_MLOAD: begin c.use_prod = 1'b1; c.wr = 1'b1; end
            OP_MAC:   begin c.use_prod = 1'b1; c.accumulate = 1'b1; c.wr = 1'b1; end
            OP_MSUB:  begin c.use_prod = 1'b1; c.accumulate = 1'b1; c.subtract = 1'b1; c.wr = 1'b1; end
            OP_ADD:   begin c.accumulate = 1'b1; c.wr = 1'b1; end
            OP_SUB:   begin c.accumulate = 1'b1; c.subtract = 1'b1; c.wr = 1'b1; end
            OP_PASS:  begin c.wr = 1'b1; end
            OP_CLR:   begin c.load_zero = 1'b1; c.clr_ovf = 1'b1; c.wr = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
    parameter int unsigned OP_W  = mac_pkg::OPND_W,
    parameter int unsigned ACC_W = mac_pkg::ACCU_W
) (
    input  logic signed [OP_W-1:0]  a_i,
    input  logic signed [OP_W-1:0]  b_i,
    output logic        [ACC_W-1:0] prod_o
);
    localparam int unsigned PW = 2 * OP_W;
    localparam int unsigned SH = PW - ACC_W;

    logic signed [PW-1:0] full;

    always_comb begin
        full   = a_i * b_i;
        prod_o = full[PW-1:SH];   // drop low SH bits: floor toward -inf
    end
endmodule

// File: rtl/mac_alu.sv
module mac_alu #(
    parameter int unsigned ACC_W = mac_pkg::ACCU_W
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [ACC_W-1:0] opnd_i,
    input  mac_pkg::ctl_t    ctl_i,
    input  logic             sat_i,
    output logic [ACC_W-1:0] res_o,
    output logic             ovf_o
);
    localparam logic [ACC_W-1:0] POS_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] base, ext, sum;

    always_comb begin
        base  = ctl_i.accumulate ? {acc_i[ACC_W-1], acc_i} : '0;
        ext   = {opnd_i[ACC_W-1], opnd_i};
        sum   = ctl_i.subtract ? (base - ext) : (base + ext);
        ovf_o = ctl_i.accumulate && (sum[ACC_W] != sum[ACC_W-1]);
        if (ovf_o && sat_i)
            res_o = sum[ACC_W] ? NEG_MIN : POS_MAX;
        else
            res_o = sum[ACC_W-1:0];
    end

    // R9: a clamped result is one of the two range limits
    always_comb begin
        if (ovf_o && sat_i)
            a_r9_clamp_value: assert (res_o == POS_MAX || res_o == NEG_MIN);
    end
endmodule

// File: rtl/mac_trunc_dp.sv
module mac_trunc_dp #(
    parameter int unsigned OP_W  = mac_pkg::OPND_W,
    parameter int unsigned ACC_W = mac_pkg::ACCU_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [2:0]       op_i,
    input  logic [OP_W-1:0]  opa_i,
    input  logic [OP_W-1:0]  opb_i,
    input  logic             sat_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             ovf_o
);
    import mac_pkg::*;

    localparam int unsigned EXT_W = ACC_W - OP_W;

    ctl_t             ctl;
    logic [ACC_W-1:0] prod, opa_ext, opnd, alu_res, nxt;
    logic             alu_ovf;

    mac_mul #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (prod)
    );

    always_comb begin
        ctl     = decode_op(op_e'(op_i));
        opa_ext = {{EXT_W{opa_i[OP_W-1]}}, opa_i};
        opnd    = ctl.use_prod ? prod : opa_ext;
    end

    mac_alu #(.ACC_W(ACC_W)) u_alu (
        .acc_i  (acc_o),
        .opnd_i (opnd),
        .ctl_i  (ctl),
        .sat_i  (sat_i),
        .res_o  (alu_res),
        .ovf_o  (alu_ovf)
    );

    assign nxt = ctl.load_zero ? '0 : alu_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o  <= '0;
            zero_o <= 1'b1;
            neg_o  <= 1'b0;
            ovf_o  <= 1'b0;
        end else if (valid_i && ctl.wr) begin
            acc_o  <= nxt;
            zero_o <= (nxt == '0);
            neg_o  <= nxt[ACC_W-1];
            ovf_o  <= ctl.clr_ovf ? 1'b0 : (ovf_o | alu_ovf);
        end
    end

    // R10: flags track the accumulator
    a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
        zero_o == (acc_o == '0));
    a_r10_neg_flag: assert property (@(posedge clk) disable iff (rst)
        neg_o == acc_o[ACC_W-1]);
    // R11: idle or reserved cycle holds all state
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!valid_i || op_i == 3'd7) |=> ($stable(acc_o) && $stable(ovf_o)));
    // R8: sticky overflow survives anything but clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !(valid_i && op_i == 3'd6)) |=> ovf_o);
    // R7: clear empties accumulator and overflow
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd6) |=> (acc_o == '0 && !ovf_o));
    // R2: multiply-load never raises overflow
    a_r2_mload_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd0 && !ovf_o) |=> !ovf_o);
endmodule

// File: tb/test_mac_trunc_dp.sv
module test_mac_trunc_dp;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [15:0] opa_i, opb_i;
    logic        sat_i;
    logic [23:0] acc_o;
    logic        zero_o, neg_o, ovf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    longint m_acc = 0;
    bit     m_ovf = 1'b0;

    always #5 clk = ~clk;

    mac_trunc_dp i_mac_trunc_dp (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
        .opa_i(opa_i), .opb_i(opb_i), .sat_i(sat_i),
        .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
    );

    function automatic logic [15:0] pick(input int i);
        if (i < 16) return 16'(-32768 + i * 4369);
        if (i == 16) return 16'hFFFF;
        return 16'h0001;
    endfunction

    function automatic longint fix(input longint r, input bit sat);
        longint t;
        if (r > 8388607 || r < -8388608) begin
            m_ovf = 1'b1;
            if (sat) return (r > 0) ? 64'sd8388607 : -64'sd8388608;
            t = (r + 8388608) % 16777216;
            if (t < 0) t = t + 16777216;
            return t - 8388608;
        end
        return r;
    endfunction

    function automatic void model(input logic [2:0] op, input logic [15:0] a,
                                  input logic [15:0] b, input bit sat);
        longint sa, x;
        sa = longint'($signed(a));
        x  = (sa * longint'($signed(b))) >>> 8;
        case (op)
            3'd0: m_acc = x;
            3'd1: m_acc = fix(m_acc + x, sat);
            3'd2: m_acc = fix(m_acc - x, sat);
            3'd3: m_acc = fix(m_acc + sa, sat);
            3'd4: m_acc = fix(m_acc - sa, sat);
            3'd5: m_acc = sa;
            3'd6: begin m_acc = 0; m_ovf = 1'b0; end
            default: ;
        endcase
    endfunction

    task automatic check(input string tag);
        logic [23:0] ea;
        ea = 24'(m_acc);
        checks++;
        if (acc_o !== ea || zero_o !== (ea == 0) || neg_o !== ea[23] || ovf_o !== m_ovf) begin
            errors++;
            $display("FAIL %s acc=%h z=%b n=%b v=%b expected acc=%h z=%b n=%b v=%b",
                     tag, acc_o, zero_o, neg_o, ovf_o, ea, (ea == 0), ea[23], m_ovf);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input bit sat, input bit v, input string tag);
        @(negedge clk);
        valid_i = v; op_i = op; opa_i = a; opb_i = b; sat_i = sat;
        if (v) model(op, a, b, sat);
        @(posedge clk);
        #2;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid_i = 1'b0;
        @(posedge clk);
        #2;
        m_acc = 0; m_ovf = 1'b0;
        check("R1 reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; valid_i = 1'b0; op_i = 3'd0; opa_i = '0; opb_i = '0; sat_i = 1'b0;
        do_reset();

        // R2: multiply-load grid incl. corners
        for (int i = 0; i < 18; i++)
            for (int j = 0; j < 18; j++)
                run(3'd0, pick(i), pick(j), 1'b0, 1'b1, "R2 mload");

        run(3'd6, 16'h1234, 16'h5678, 1'b0, 1'b1, "R7 clear");

        // R3/R8: wrap upward, overflow sticks
        run(3'd0, 16'h7FFF, 16'h7FFF, 1'b0, 1'b1, "R2 mload max");
        for (int k = 0; k < 4; k++) run(3'd1, 16'h7FFF, 16'h7FFF, 1'b0, 1'b1, "R3 mac wrap");
        for (int k = 0; k < 3; k++) run(3'd1, 16'h0100, 16'h0001, 1'b0, 1'b1, "R8 sticky");
        for (int k = 0; k < 6; k++) run(3'd1, 16'h8000, 16'h7FFF, 1'b0, 1'b1, "R3 mac wrap neg");
        run(3'd6, 16'h0, 16'h0, 1'b0, 1'b1, "R7 clear ovf");

        // R9: saturation both directions
        for (int k = 0; k < 4; k++) run(3'd1, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, "R9 sat pos");
        for (int k = 0; k < 6; k++) run(3'd2, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, "R9 sat neg msub");
        for (int k = 0; k < 3; k++) run(3'd4, 16'h7FFF, 16'h0, 1'b1, 1'b1, "R9 sat sub");
        run(3'd6, 16'h0, 16'h0, 1'b0, 1'b1, "R7 clear");

        // R4: multiply-subtract sweep
        for (int i = 0; i < 18; i++)
            run(3'd2, pick(i), pick(17 - i), 1'b0, 1'b1, "R4 msub");
        run(3'd6, 16'h0, 16'h0, 1'b0, 1'b1, "R7 clear");

        // R5: add/sub ignore opb
        for (int i = 0; i < 18; i++) begin
            run(3'd3, pick(i), pick(17 - i), 1'b0, 1'b1, "R5 add");
            run(3'd4, pick(17 - i), pick(i), 1'b0, 1'b1, "R5 sub");
        end

        // R6/R10: pass values incl. zero and negative
        for (int i = 0; i < 18; i++)
            run(3'd5, pick(i), 16'hAAAA, 1'b0, 1'b1, "R6 pass");
        run(3'd5, 16'h0000, 16'h1111, 1'b0, 1'b1, "R10 zero flag");
        run(3'd5, 16'h8001, 16'h1111, 1'b0, 1'b1, "R10 neg flag");

        // R11: idle and reserved code hold state
        run(3'd1, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, "R11 valid low");
        run(3'd6, 16'h0, 16'h0, 1'b0, 1'b0, "R11 valid low clr");
        run(3'd7, 16'h7FFF, 16'h7FFF, 1'b0, 1'b1, "R11 reserved");

        // R1: reset after activity
        run(3'd5, 16'h4321, 16'h0, 1'b0, 1'b1, "R6 pass");
        do_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule